// File: doc/BRIEF.md
# Clock-Control Register Bank with PLL Status Words

This block is a small bank of 32-bit control registers on a word-addressed bus with separate read and write strobes. It stores clock-gate masks, a clock-source selection word, two divider words and four PLL configuration words. It also decodes a write-only software-reset word and a read-only counter word. The bank only stores and reports values. It does not drive any PLL or clock divider.

The PLL words behave differently from the others. Bit 31 reports lock, bit 30 is a sticky loss-of-lock flag and bit 12 requests power-down. The two status bits are not stored as written. On every write they are recomputed from the power-down bit of the incoming word and, for the sticky flag, from its previous value.

Illegal accesses produce a one-cycle error pulse and leave the stored state unchanged. Illegal accesses are: an index past the end of the bank, a misaligned byte address, a read of the write-only word and a write to the read-only word. Read data and the error flag are registered, so both appear one clock after the strobe.

Top module: `clkreg_bank`

## Requirements
- R1: After reset, the registers read as follows. Index 0 (byte 0x00), index 6 (0x18) and index 7 (0x1C) read 0xFFFFFFFF. Index 1 (0x04) reads 0x004AAAAA. The PLL words read 0x80222101 at index 3 (0x0C), 0x80202101 at index 4 (0x10), 0x80C02105 at index 8 (0x20) and 0x81228606 at index 9 (0x24). Index 2 (0x08) and index 10 (0x28) read 0.
- R2: A write to index 0, 1, 2, 6, 7 or 10 stores the data verbatim. A read samples the stored word and presents it on rdata one clock after the strobe.
- R3: A write to a PLL word (index 3, 4, 8 or 9) with bit 12 set stores the written word with bit 31 cleared and bit 30 set.
- R4: A write to a PLL word with bit 12 clear stores the written word with bit 31 set. Bit 30 becomes the old bit 30 AND NOT the written bit 30: writing 1 clears the flag and writing 0 leaves it unchanged.
- R5: Index 5 (0x14) is write-only. A write to it raises no error and changes nothing. A read of it returns 0 and pulses err.
- R6: Index 11 (0x2C) is read-only and reads 0. A write to it is discarded and pulses err.
- R7: An access to an index of 12 or above (byte address 0x030 to 0xFFC) reads 0, modifies no register and pulses err.
- R8: An access whose byte address has bits [1:0] nonzero is illegal. It reads 0, writes nothing and pulses err.
- R9: err is high for exactly the one cycle after an illegal access and stays low after legal accesses and idle cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low cold reset |
| rd_en | input | 1 | Read strobe, one cycle per access |
| wr_en | input | 1 | Write strobe, one cycle per access |
| addr | input | 12 | Byte address in the 4 KiB window |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data, valid the cycle after rd_en |
| err | output | 1 | One-cycle pulse after an illegal access |

## Verification
The PLL status logic gets the most attention. Power-down writes are sent with and without bit 31 set in the data, which shows that the lock bit is computed and not copied. Run-mode writes are sent with bit 30 at 0 and at 1 while the sticky flag is already set, which separates "keep" from "clear" from a naive copy of the written bit. Ordinary registers get distinct patterns so that aliasing between indices would show. Write-only, read-only, out-of-range and misaligned addresses are each followed by a read of a neighbouring word, to confirm nothing changed.

// File: rtl/clkreg_pkg.sv
// Package: register indices, access kinds, reset values and PLL bit positions
// for the clock-control register bank. Assumes 32-bit data words.
package clkreg_pkg;
    localparam int DW        = 32;
    localparam int NREGS     = 12;
    localparam int LOCK_B    = 31;
    localparam int SLIP_B    = 30;
    localparam int PD_B      = 12;

    localparam int IX_GATE_A = 0;
    localparam int IX_SRCSEL = 1;
    localparam int IX_DIV_A  = 2;
    localparam int IX_PLL0   = 3;
    localparam int IX_PLL1   = 4;
    localparam int IX_SWRST  = 5;
    localparam int IX_GATE_B = 6;
    localparam int IX_GATE_C = 7;
    localparam int IX_PLL2   = 8;
    localparam int IX_PLLG   = 9;
    localparam int IX_DIV_B  = 10;
    localparam int IX_TICK   = 11;

    typedef enum logic [1:0] {K_RW, K_PLL, K_WO, K_RO} kind_e;

    // Access kind of a register index.
    function automatic kind_e kind_of(input int i);
        case (i)
            IX_PLL0, IX_PLL1, IX_PLL2, IX_PLLG: return K_PLL;
            IX_SWRST:                           return K_WO;
            IX_TICK:                            return K_RO;
            default:                            return K_RW;
        endcase
    endfunction

    // Cold-reset value of a register index.
    function automatic logic [DW-1:0] rst_of(input int i);
        case (i)
            IX_GATE_A, IX_GATE_B, IX_GATE_C: return '1;
            IX_SRCSEL:                       return 32'h004A_AAAA;
            IX_PLL0:                         return 32'h8022_2101;
            IX_PLL1:                         return 32'h8020_2101;
            IX_PLL2:                         return 32'h80C0_2105;
            IX_PLLG:                         return 32'h8122_8606;
            default:                         return '0;
        endcase
    endfunction
endpackage

// File: rtl/clkreg_decode.sv
// Address decoder: splits a byte address into a word index and classifies
// the current access as legal read, legal write or illegal.
// Assumes at most one of rd_en / wr_en per cycle is meaningful.
module clkreg_decode
    import clkreg_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int NUM_R  = NREGS,
    localparam int IDX_W = ADDR_W - 2
) (
    input  logic              rd_en,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    output logic [IDX_W-1:0]  idx,
    output logic              rd_ok,
    output logic              wr_ok,
    output logic              bad
);
    logic  aligned, in_range, rd_legal, wr_legal;
    kind_e kind;

    // Classify the address and derive legality per access direction.
    always_comb begin
        idx      = addr[ADDR_W-1:2];
        aligned  = (addr[1:0] == 2'b00);
        in_range = (idx < IDX_W'(NUM_R));
        kind     = in_range ? kind_of(int'(idx)) : K_RO;
        rd_legal = aligned && in_range && (kind != K_WO);
        wr_legal = aligned && in_range && (kind != K_RO);
        rd_ok    = rd_en && rd_legal;
        wr_ok    = wr_en && wr_legal;
        bad      = (rd_en && !rd_legal) || (wr_en && !wr_legal);
    end
endmodule

// File: rtl/clkreg_pll_update.sv
// PLL word update: computes the value stored on a write to a PLL word,
// rewriting the lock and sticky loss-of-lock bits from the power-down bit.
module clkreg_pll_update
    import clkreg_pkg::*;
(
    input  logic [DW-1:0] cur,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] nxt
);
    // Power-down forces unlocked + lost; run mode forces locked, W1C on the flag.
    always_comb begin
        nxt = wdata;
        if (wdata[PD_B]) begin
            nxt[LOCK_B] = 1'b0;
            nxt[SLIP_B] = 1'b1;
        end else begin
            nxt[LOCK_B] = 1'b1;
            nxt[SLIP_B] = cur[SLIP_B] & ~wdata[SLIP_B];
        end
    end
endmodule

// File: rtl/clkreg_bank.sv
// Clock-control register bank top. Holds the storage for the read/write and
// PLL words, ties the write-only and read-only words to zero, and registers
// read data and the error pulse. Assumes synchronous active-low reset.
module clkreg_bank
    import clkreg_pkg::*;
#(
    parameter int ADDR_W = 12,
    localparam int IDX_W = ADDR_W - 2,
    localparam int SEL_W = $clog2(NREGS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DW-1:0]     wdata,
    output logic [DW-1:0]     rdata,
    output logic              err
);
    logic [IDX_W-1:0] idx;
    logic             rd_ok, wr_ok, bad;
    logic [DW-1:0]    regs [NREGS];
    logic [DW-1:0]    rdata_q;
    logic             err_q;

    clkreg_decode #(.ADDR_W(ADDR_W), .NUM_R(NREGS)) dec_i (
        .rd_en(rd_en), .wr_en(wr_en), .addr(addr),
        .idx(idx), .rd_ok(rd_ok), .wr_ok(wr_ok), .bad(bad)
    );

    for (genvar i = 0; i < NREGS; i++) begin : g_reg
        localparam kind_e KIND = kind_of(i);
        if (KIND == K_PLL) begin : g_pll
            logic [DW-1:0] pll_nxt;
            clkreg_pll_update upd_i (.cur(regs[i]), .wdata(wdata), .nxt(pll_nxt));
            // Store the PLL word with recomputed status bits.
            always_ff @(posedge clk) begin
                if (!rst_n)                                 regs[i] <= rst_of(i);
                else if (wr_ok && idx == IDX_W'(i))         regs[i] <= pll_nxt;
            end
            a_r3_pd_status: assert property (@(posedge clk) disable iff (!rst_n)
                (wr_en && addr == ADDR_W'(i*4) && wdata[PD_B])
                |=> (regs[i][LOCK_B:SLIP_B] == 2'b01));
            a_r4_run_status: assert property (@(posedge clk) disable iff (!rst_n)
                (wr_en && addr == ADDR_W'(i*4) && !wdata[PD_B])
                |=> (regs[i][LOCK_B] &&
                     regs[i][SLIP_B] == ($past(regs[i][SLIP_B]) && !$past(wdata[SLIP_B]))));
        end else if (KIND == K_RW) begin : g_rw
            // Store ordinary words verbatim.
            always_ff @(posedge clk) begin
                if (!rst_n)                                 regs[i] <= rst_of(i);
                else if (wr_ok && idx == IDX_W'(i))         regs[i] <= wdata;
            end
            a_r2_verbatim: assert property (@(posedge clk) disable iff (!rst_n)
                (wr_en && addr == ADDR_W'(i*4)) |=> (regs[i] == $past(wdata)));
        end else begin : g_const
            // Write-only and read-only words hold no state.
            assign regs[i] = '0;
        end
    end

    // Register read data on each read strobe; illegal reads return zero.
    always_ff @(posedge clk) begin
        if (!rst_n)     rdata_q <= '0;
        else if (rd_en) rdata_q <= rd_ok ? regs[idx[SEL_W-1:0]] : '0;
    end

    // Register the one-cycle error pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) err_q <= 1'b0;
        else        err_q <= bad;
    end

    assign rdata = rdata_q;
    assign err   = err_q;

    a_r5_wo_read: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !wr_en && addr == ADDR_W'(IX_SWRST*4)) |=> (rdata == '0 && err));
    a_r6_ro_write: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == ADDR_W'(IX_TICK*4)) |=> err);
    a_r7_range: assert property (@(posedge clk) disable iff (!rst_n)
        ((rd_en || wr_en) && addr[ADDR_W-1:2] >= IDX_W'(NREGS)) |=> err);
    a_r8_misaligned: assert property (@(posedge clk) disable iff (!rst_n)
        ((rd_en || wr_en) && addr[1:0] != 2'b00) |=> err);
    a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_en && !wr_en) |=> !err);
endmodule

// File: tb/clkreg_bank_tb.sv
// Bench for clkreg_bank: a vector table walked by one loop, then directed
// tests for error pulse width and mid-run reset.
module clkreg_bank_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rd_en = 1'b0;
    logic        wr_en = 1'b0;
    logic [11:0] addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        err;
    int          n_chk = 0;
    int          n_bad = 0;
    bit          done = 1'b0;

    always #10 clk = ~clk;

    clkreg_bank dut_i (
        .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .wr_en(wr_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .err(err)
    );

    typedef struct packed {
        logic        wr;
        logic [11:0] a;
        logic [31:0] d;
        logic [31:0] exp;
        logic        e;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 36;
    localparam vec_t VEC [NV] = '{
        '{1'b0, 12'h000, 32'h0, 32'hFFFF_FFFF, 1'b0, 4'd1},  // R1 gate A
        '{1'b0, 12'h004, 32'h0, 32'h004A_AAAA, 1'b0, 4'd1},  // R1 source select
        '{1'b0, 12'h008, 32'h0, 32'h0000_0000, 1'b0, 4'd1},  // R1 divider A
        '{1'b0, 12'h00C, 32'h0, 32'h8022_2101, 1'b0, 4'd1},  // R1 PLL0
        '{1'b0, 12'h010, 32'h0, 32'h8020_2101, 1'b0, 4'd1},  // R1 PLL1
        '{1'b0, 12'h018, 32'h0, 32'hFFFF_FFFF, 1'b0, 4'd1},  // R1 gate B
        '{1'b0, 12'h01C, 32'h0, 32'hFFFF_FFFF, 1'b0, 4'd1},  // R1 gate C
        '{1'b0, 12'h020, 32'h0, 32'h80C0_2105, 1'b0, 4'd1},  // R1 PLL2
        '{1'b0, 12'h024, 32'h0, 32'h8122_8606, 1'b0, 4'd1},  // R1 PLLG
        '{1'b0, 12'h028, 32'h0, 32'h0000_0000, 1'b0, 4'd1},  // R1 divider B
        '{1'b1, 12'h008, 32'h1234_5678, 32'h0, 1'b0, 4'd2},  // R2 write
        '{1'b1, 12'h028, 32'hA5A5_0F0F, 32'h0, 1'b0, 4'd2},  // R2 write
        '{1'b0, 12'h008, 32'h0, 32'h1234_5678, 1'b0, 4'd2},  // R2 read back
        '{1'b0, 12'h028, 32'h0, 32'hA5A5_0F0F, 1'b0, 4'd2},  // R2 no aliasing
        '{1'b1, 12'h00C, 32'h0055_3000, 32'h0, 1'b0, 4'd3},  // R3 power down
        '{1'b0, 12'h00C, 32'h0, 32'h4055_3000, 1'b0, 4'd3},
        '{1'b1, 12'h024, 32'h8000_1001, 32'h0, 1'b0, 4'd3},  // R3 lock bit not copied
        '{1'b0, 12'h024, 32'h0, 32'h4000_1001, 1'b0, 4'd3},
        '{1'b1, 12'h00C, 32'h0022_2101, 32'h0, 1'b0, 4'd4},  // R4 flag kept
        '{1'b0, 12'h00C, 32'h0, 32'hC022_2101, 1'b0, 4'd4},
        '{1'b1, 12'h00C, 32'h4022_2101, 32'h0, 1'b0, 4'd4},  // R4 flag cleared by 1
        '{1'b0, 12'h00C, 32'h0, 32'h8022_2101, 1'b0, 4'd4},
        '{1'b1, 12'h010, 32'h4000_0000, 32'h0, 1'b0, 4'd4},  // R4 clearing a clear flag
        '{1'b0, 12'h010, 32'h0, 32'h8000_0000, 1'b0, 4'd4},
        '{1'b1, 12'h014, 32'hFFFF_FFFF, 32'h0, 1'b0, 4'd5},  // R5 write-only write
        '{1'b0, 12'h014, 32'h0, 32'h0000_0000, 1'b1, 4'd5},  // R5 write-only read
        '{1'b1, 12'h02C, 32'hDEAD_BEEF, 32'h0, 1'b1, 4'd6},  // R6 read-only write
        '{1'b0, 12'h02C, 32'h0, 32'h0000_0000, 1'b0, 4'd6},  // R6 still zero
        '{1'b1, 12'h030, 32'h1111_1111, 32'h0, 1'b1, 4'd7},  // R7 first bad index
        '{1'b0, 12'h030, 32'h0, 32'h0000_0000, 1'b1, 4'd7},
        '{1'b1, 12'hFFC, 32'h2222_2222, 32'h0, 1'b1, 4'd7},  // R7 last word of window
        '{1'b0, 12'h000, 32'h0, 32'hFFFF_FFFF, 1'b0, 4'd7},  // R7 no alias to index 0
        '{1'b1, 12'h009, 32'h0000_0000, 32'h0, 1'b1, 4'd8},  // R8 misaligned write
        '{1'b0, 12'h008, 32'h0, 32'h1234_5678, 1'b0, 4'd8},  // R8 word untouched
        '{1'b0, 12'h00A, 32'h0, 32'h0000_0000, 1'b1, 4'd8},  // R8 misaligned read
        '{1'b0, 12'h004, 32'h0, 32'h004A_AAAA, 1'b0, 4'd9}   // R9 legal read, no error
    };

    task automatic cmp(input logic [31:0] act, input logic [31:0] exp,
                       input int req, input string what);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic bus_op(input logic w, input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        rd_en = !w; wr_en = w; addr = a; wdata = d;
        @(negedge clk);
        rd_en = 1'b0; wr_en = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        cmp(rdata, 32'h0, 1, "rdata in reset");          // R1
        cmp({31'b0, err}, 32'h0, 9, "err in reset");     // R9
        rst_n = 1'b1;

        for (int k = 0; k < NV; k++) begin
            bus_op(VEC[k].wr, VEC[k].a, VEC[k].d);
            if (!VEC[k].wr) cmp(rdata, VEC[k].exp, int'(VEC[k].req), "read data");
            cmp({31'b0, err}, {31'b0, VEC[k].e}, int'(VEC[k].req), "err flag");
        end

        // R9: the error pulse lasts one cycle only.
        bus_op(1'b0, 12'h040, 32'h0);
        cmp({31'b0, err}, 32'h1, 9, "err pulse high");
        @(negedge clk);
        cmp({31'b0, err}, 32'h0, 9, "err pulse drops");

        // R1: a reset mid-run restores cold values.
        bus_op(1'b1, 12'h008, 32'hCAFE_0001);
        bus_op(1'b1, 12'h020, 32'h0000_1000);
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk); rst_n = 1'b1;
        bus_op(1'b0, 12'h008, 32'h0);
        cmp(rdata, 32'h0, 1, "divider A after reset");
        bus_op(1'b0, 12'h020, 32'h0);
        cmp(rdata, 32'h80C0_2105, 1, "PLL2 after reset");

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule